// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the register file and transfer path of a small 16-bit accumulator machine. It has one 16-bit bus. A 3-bit select input picks which source drives it: one of six registers or a word memory. Registers take a value off the bus when their load strobe is high at a clock edge. Every register also has its own clear and increment strobes. The memory is addressed only by the address register. It writes the bus value when its write strobe is high, and it drives the bus with the word at that address when the select code asks for memory.

The accumulator is different from the others. Its load strobe takes a value from a separate ALU result port, never from the bus. Because of this, one register can load from the bus while the accumulator loads from the ALU in the same cycle, for example a swap between the data register and the accumulator. Only one source drives the bus at a time, because the select is a single code. The address register and the program counter are 12 bits wide. When either one drives the bus, the upper bus bits are zero. The sequencer that generates the strobes and the ALU itself are outside this block.

Top module: `bus_datapath`

## Requirements
- R1: The bus value follows `bus_sel` in the same cycle: 0 gives all zeros, 1 gives the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register, and 7 the memory word at the address register.
- R2: The address register and the program counter are 12 bits wide. When either drives the bus, bus bits 15..12 are zero.
- R3: Strobe vectors use bit index 0 for the address register, 1 the program counter, 2 the data register, 3 the accumulator, 4 the instruction register and 5 the temporary register. A register whose `reg_ld` bit is high captures the bus on the rising clock edge. The 12-bit registers capture bus bits 11..0.
- R4: When several strobes are high on one register in the same cycle, clear wins over load, and load wins over increment. Clear sets the register to zero.
- R5: An increment adds one. The 12-bit registers wrap from 4095 to 0, and the 16-bit registers wrap from 65535 to 0.
- R6: When `mem_wr` is high, the memory word at the address register takes the bus value at the clock edge. Selecting code 7 in a later cycle returns that word.
- R7: The accumulator loads `alu_result` when `ac_alu_ld` is high. `reg_ld[3]` has no effect on it.
- R8: In one cycle, the data register can load the accumulator over the bus while the accumulator loads the old data register value through `alu_result`.
- R9: While `rst_n` is low, all six registers go to zero.
- R10: A register with none of its strobes high keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_sel | input | 3 | Bus source code |
| reg_ld | input | 6 | Per-register load from bus (bit 3 unused) |
| reg_inr | input | 6 | Per-register increment |
| reg_clr | input | 6 | Per-register clear |
| ac_alu_ld | input | 1 | Accumulator load from ALU result |
| alu_result | input | 16 | ALU result word |
| mem_wr | input | 1 | Write bus value to memory at address register |
| bus_data | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
The bus value depends only on logic, so the bench reads `bus_data` 2 ns after it drives the inputs, before the next rising edge. Register and memory updates take effect at the next rising edge, and the bench checks all six registers at the falling edge that follows. Memory contents are checked by selecting code 7 in a later cycle. The bench model is updated at that same point, so every expected value is tied to exactly one edge.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int NUM_REGS = 6;
  localparam int SEL_W    = 3;
  localparam int IDX_AR   = 0;
  localparam int IDX_PC   = 1;
  localparam int IDX_DR   = 2;
  localparam int IDX_AC   = 3;
  localparam int IDX_IR   = 4;
  localparam int IDX_TR   = 5;
  localparam logic [SEL_W-1:0] SEL_NONE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MEM  = 3'd7;
endpackage

// File: rtl/bdp_reg.sv
module bdp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (ld)   q <= d;
    else if (inr)  q <= q + W'(1);
  end

  assert_clear_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  assert_load_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (q == $past(d)));
  assert_incr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inr && !ld && !clr) |=> (q == W'($past(q) + W'(1))));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inr && !ld && !clr) |=> $stable(q));
endmodule

// File: rtl/bdp_mem.sv
module bdp_mem #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[addr] <= wdata;
  end

  assign rdata = words[addr];
endmodule

// File: rtl/bdp_bus_mux.sv
module bdp_bus_mux
  import bdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [SEL_W-1:0]              sel,
  input  logic [NUM_REGS-1:0][DW-1:0]   reg_src,
  input  logic [DW-1:0]                 mem_src,
  output logic [DW-1:0]                 bus
);
  always_comb begin
    if (sel == SEL_NONE)     bus = '0;
    else if (sel == SEL_MEM) bus = mem_src;
    else                     bus = reg_src[sel - 3'd1];
  end
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import bdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    bus_sel,
  input  logic [NUM_REGS-1:0] reg_ld,
  input  logic [NUM_REGS-1:0] reg_inr,
  input  logic [NUM_REGS-1:0] reg_clr,
  input  logic                ac_alu_ld,
  input  logic [DATA_W-1:0]   alu_result,
  input  logic                mem_wr,
  output logic [DATA_W-1:0]   bus_data,
  output logic [ADDR_W-1:0]   ar_q,
  output logic [ADDR_W-1:0]   pc_q,
  output logic [DATA_W-1:0]   dr_q,
  output logic [DATA_W-1:0]   ac_q,
  output logic [DATA_W-1:0]   ir_q,
  output logic [DATA_W-1:0]   tr_q
);
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_ext;
  logic [DATA_W-1:0]               mem_rdata;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam int RW = (g == IDX_AR || g == IDX_PC) ? ADDR_W : DATA_W;
    logic [RW-1:0] d_in;
    logic          ld_in;
    logic [RW-1:0] q_out;
    if (g == IDX_AC) begin : g_alu_src
      assign d_in  = alu_result[RW-1:0];
      assign ld_in = ac_alu_ld;
    end else begin : g_bus_src
      assign d_in  = bus_data[RW-1:0];
      assign ld_in = reg_ld[g];
    end
    bdp_reg #(.W(RW)) u_reg (
      .clk(clk), .rst_n(rst_n), .clr(reg_clr[g]), .ld(ld_in),
      .inr(reg_inr[g]), .d(d_in), .q(q_out)
    );
    assign reg_ext[g] = DATA_W'(q_out);
  end

  bdp_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we(mem_wr), .addr(ar_q), .wdata(bus_data), .rdata(mem_rdata)
  );

  bdp_bus_mux #(.DW(DATA_W)) u_mux (
    .sel(bus_sel), .reg_src(reg_ext), .mem_src(mem_rdata), .bus(bus_data)
  );

  assign ar_q = reg_ext[IDX_AR][ADDR_W-1:0];
  assign pc_q = reg_ext[IDX_PC][ADDR_W-1:0];
  assign dr_q = reg_ext[IDX_DR];
  assign ac_q = reg_ext[IDX_AC];
  assign ir_q = reg_ext[IDX_IR];
  assign tr_q = reg_ext[IDX_TR];

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_NONE) |-> (bus_data == '0));
  assert_ar_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 3'd1) |-> (bus_data == DATA_W'(ar_q)));
  assert_pc_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 3'd2) |-> (bus_data == DATA_W'(pc_q)));
  assert_ac_no_bus_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld[IDX_AC] && !ac_alu_ld && !reg_inr[IDX_AC] && !reg_clr[IDX_AC])
      |=> $stable(ac_q));
  assert_mem_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ((bus_sel != SEL_MEM) || !$stable(ar_q) || (bus_data == $past(bus_data))));
endmodule

// File: tb/tb_bus_datapath.sv
module tb_bus_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [5:0]  reg_ld = '0, reg_inr = '0, reg_clr = '0;
  logic        ac_alu_ld = 1'b0;
  logic [15:0] alu_result = '0;
  logic        mem_wr = 1'b0;
  logic [15:0] bus_data, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] m_reg [6];
  logic [15:0] m_mem [4096];
  bit          m_vld [4096];

  always #10 clk = ~clk;

  bus_datapath dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .reg_ld(reg_ld),
    .reg_inr(reg_inr), .reg_clr(reg_clr), .ac_alu_ld(ac_alu_ld),
    .alu_result(alu_result), .mem_wr(mem_wr), .bus_data(bus_data),
    .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q)
  );

  function automatic logic [15:0] wmask(int i);
    return (i < 2) ? 16'h0FFF : 16'hFFFF;
  endfunction

  function automatic logic [15:0] exp_bus(logic [2:0] s);
    if (s == 3'd0) return 16'h0000;
    if (s == 3'd7) return m_mem[m_reg[0][11:0]];
    return m_reg[int'(s) - 1];
  endfunction

  function automatic logic [15:0] dut_reg(int i);
    case (i)
      0: return {4'h0, ar_q};
      1: return {4'h0, pc_q};
      2: return dr_q;
      3: return ac_q;
      4: return ir_q;
      default: return tr_q;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, logic [2:0] s, logic [5:0] ld, logic [5:0] inr,
                      logic [5:0] clr, logic acl, logic [15:0] alu, logic mw);
    logic [15:0] eb;
    logic [15:0] nx [6];
    bus_sel = s; reg_ld = ld; reg_inr = inr; reg_clr = clr;
    ac_alu_ld = acl; alu_result = alu; mem_wr = mw;
    #2;
    eb = exp_bus(s);
    chk(tag, "bus", bus_data, eb);
    for (int i = 0; i < 6; i++) begin
      logic lde;
      logic [15:0] d;
      lde = (i == 3) ? acl : ld[i];
      d   = (i == 3) ? alu : (eb & wmask(i));
      if (clr[i])      nx[i] = 16'h0;
      else if (lde)    nx[i] = d;
      else if (inr[i]) nx[i] = (m_reg[i] + 16'h1) & wmask(i);
      else             nx[i] = m_reg[i];
    end
    if (mw) begin
      m_mem[m_reg[0][11:0]] = eb;
      m_vld[m_reg[0][11:0]] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      m_reg[i] = nx[i];
      chk(tag, $sformatf("reg%0d", i), dut_reg(i), nx[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 6; i++) m_reg[i] = 16'h0;
    for (int a = 0; a < 4096; a++) m_vld[a] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, R1: code 0 is zero
    step("R9", 3'd0, 6'h00, 6'h00, 6'h00, 1'b0, 16'h0, 1'b0);
    // R7: accumulator from ALU
    step("R7", 3'd0, 6'h00, 6'h00, 6'h00, 1'b1, 16'hFFFF, 1'b0);
    // R3: AR and TR load from bus (AC)
    step("R3", 3'd4, 6'h21, 6'h00, 6'h00, 1'b0, 16'h0, 1'b0);
    // R2: AR zero-extended on bus
    step("R2", 3'd1, 6'h04, 6'h00, 6'h00, 1'b0, 16'h0, 1'b0);
    // R5: wraps of AR (4095) and TR (65535)
    step("R5", 3'd0, 6'h00, 6'h23, 6'h00, 1'b0, 16'h0, 1'b0);
    // R4: priority
    step("R4", 3'd4, 6'h20, 6'h20, 6'h20, 1'b0, 16'h0, 1'b0);
    step("R4", 3'd4, 6'h20, 6'h20, 6'h00, 1'b0, 16'h0, 1'b0);
    step("R4", 3'd0, 6'h00, 6'h20, 6'h20, 1'b0, 16'h0, 1'b0);
    // R7: reg_ld[3] ignored
    step("R7", 3'd2, 6'h08, 6'h00, 6'h00, 1'b0, 16'h0, 1'b0);
    // R8: swap DR and AC
    step("R8", 3'd0, 6'h00, 6'h00, 6'h00, 1'b1, 16'h1234, 1'b0);
    step("R8", 3'd4, 6'h04, 6'h00, 6'h00, 1'b1, 16'hABCD, 1'b0);
    step("R8", 3'd4, 6'h04, 6'h00, 6'h00, 1'b1, 16'h1234, 1'b0);
    // R6: memory write and read back
    step("R6", 3'd0, 6'h00, 6'h00, 6'h00, 1'b1, 16'h0005, 1'b0);
    step("R6", 3'd4, 6'h01, 6'h00, 6'h00, 1'b1, 16'hBEEF, 1'b0);
    step("R6", 3'd4, 6'h00, 6'h00, 6'h00, 1'b0, 16'h0, 1'b1);
    step("R6", 3'd7, 6'h20, 6'h00, 6'h00, 1'b0, 16'h0, 1'b0);
    // R10: no strobes, all hold
    step("R10", 3'd4, 6'h00, 6'h00, 6'h00, 1'b0, 16'h0, 1'b0);
    // random mix: R1 R3 R4 R5 R6 R10
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s;
      logic [5:0] ld, inr, clr;
      s = 3'($urandom_range(0, 7));
      if (s == 3'd7 && !m_vld[m_reg[0][11:0]]) s = 3'd4;
      for (int b = 0; b < 6; b++) begin
        ld[b]  = ($urandom_range(0, 2) == 0);
        inr[b] = ($urandom_range(0, 3) == 0);
        clr[b] = ($urandom_range(0, 7) == 0);
      end
      step("R1_R3_R4_R5_R6_R10", s, ld, inr, clr, 1'($urandom_range(0, 1)),
           16'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule